// File: doc/BRIEF.md
# Coherent Split-Read Cycle Counter

This block holds a free-running cycle counter twice as wide as its register port. Software reads it as two halves, low half first and then high half. A new snapshot of the count is taken on every read, so the high half can move on between the two reads. The block does not freeze the high half when the low half is read. Instead it watches the order of the reads, and anything that could spoil the pair, and reports in a status bit whether the last pair fits together.

Software sets the enable bit in the control register to start counting. To read the count it takes the low half, then the high half, then the control register, and repeats the three reads while the status bit is clear. A pair is spoiled in either of two cases. The first is when the processor reports an interrupt or exception taken on the `irq_taken` input. The second is when the high half steps between the two reads. Reads never clear or reload the count.

Top module: `split_read_counter`

## Requirements
- R1: After a synchronous reset the count is zero, counting is off, `rdata` is zero and a control read returns zero.
- R2: A write to the control address 0x103 loads bit 0 of `wdata` into the enable. Every other written bit is ignored. A control read returns the enable in bit 0, the pair status in the top bit (bit HALF_W-1) and zeros elsewhere.
- R3: While enabled the count rises by exactly one every clock. While disabled it holds its value.
- R4: The high half steps by one on the same clock edge where the low half wraps from all-ones to zero.
- R5: A read (`rd_en` high) of address 0x104 returns the low half and a read of 0x105 returns the high half. Each value is the one held at the read edge and appears on `rdata` one cycle later. Reads never change the count. A read of any other address except 0x103 returns zero.
- R6: A low read followed later by a high read, with neither spoiling event in between, makes the next control read return the top bit set.
- R7: If `irq_taken` is high in any cycle from the low read through the high read, both included, the status bit reads clear.
- R8: If the high half steps at the low-read edge, or at any edge after it and before the high-read edge, the status bit reads clear. A step at the high-read edge itself does not spoil the pair.
- R9: A high read with no low read pending leaves the status bit clear. A low read always restarts the sequence and drops any earlier spoiling event.
- R10: Writes to the low and high addresses have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wdata | input | HALF_W | Write data |
| rd_en | input | 1 | Read strobe |
| irq_taken | input | 1 | Interrupt or exception taken in this cycle |
| rdata | output | HALF_W | Registered read data, valid the cycle after `rd_en` |

## Verification
Every read result is registered, so it is due on `rdata` one clock after the edge that samples `rd_en`. The value it carries is the count that was present before the increment at that same edge. The status bit depends only on reads and events at earlier edges, so a control read issued one cycle after the high read already reflects the pair. The bench drives every input on the falling edge. It records its own expected count at that moment and samples `rdata` on the next falling edge, one rising edge later. To make carry timing easy to reach, it runs with a narrow half width so that it can line up low wraps exactly at, before or between the two reads.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int unsigned DEF_ADDR_W = 12;
  localparam logic [DEF_ADDR_W-1:0] DEF_CTRL_ADDR = 12'h103;
  localparam logic [DEF_ADDR_W-1:0] DEF_LO_ADDR   = 12'h104;
  localparam logic [DEF_ADDR_W-1:0] DEF_HI_ADDR   = 12'h105;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_LO   = 2'd1,
    TRK_OK   = 2'd2,
    TRK_BAD  = 2'd3
  } trk_e;

endpackage

// File: rtl/scr_counter.sv
module scr_counter #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [HALF_W-1:0] lo,
  output logic [HALF_W-1:0] hi,
  output logic              hi_step
);
  localparam int unsigned NSEG = 2;

  logic [HALF_W-1:0] seg_q [NSEG];
  logic [NSEG-1:0]   carry;

  assign carry[0] = en;

  for (genvar g = 1; g < NSEG; g++) begin : g_chain
    // each segment steps when every lower segment is saturated
    assign carry[g] = carry[g-1] & (&seg_q[g-1]);
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q[g] <= '0;
      end else if (carry[g]) begin
        seg_q[g] <= seg_q[g] + 1'b1;
      end
    end
  end

  assign lo      = seg_q[0];
  assign hi      = seg_q[1];
  assign hi_step = carry[1];

endmodule

// File: rtl/scr_read_tracker.sv
module scr_read_tracker
  import scr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lo_rd,
  input  logic hi_rd,
  input  logic irq_taken,
  input  logic hi_step,
  output trk_e state
);
  trk_e state_q;
  logic taint_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_IDLE;
      taint_q <= 1'b0;
    end else if (lo_rd) begin
      // a low read always opens a fresh window
      state_q <= TRK_LO;
      taint_q <= hi_step | irq_taken;
    end else if (hi_rd) begin
      if (state_q == TRK_LO && !taint_q && !irq_taken) begin
        state_q <= TRK_OK;
      end else begin
        state_q <= TRK_BAD;
      end
      taint_q <= 1'b0;
    end else if (state_q == TRK_LO) begin
      taint_q <= taint_q | hi_step | irq_taken;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/scr_regport.sv
module scr_regport #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 12'h104,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 12'h105
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic [HALF_W-1:0] cnt_hi,
  input  logic              pair_ok,
  output logic              cnt_en,
  output logic              lo_rd,
  output logic              hi_rd,
  output logic [HALF_W-1:0] rdata
);
  localparam int unsigned PAD_W = HALF_W - 2;

  logic              en_q;
  logic [HALF_W-1:0] rdata_q;
  logic [HALF_W-1:0] ctrl_view;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[HALF_W-1:1];

  assign lo_rd     = rd_en && (addr == LO_ADDR);
  assign hi_rd     = rd_en && (addr == HI_ADDR);
  assign ctrl_view = {pair_ok, {PAD_W{1'b0}}, en_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (wr_en && addr == CTRL_ADDR) begin
      en_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (addr == CTRL_ADDR) begin
        rdata_q <= ctrl_view;
      end else if (lo_rd) begin
        rdata_q <= cnt_lo;
      end else if (hi_rd) begin
        rdata_q <= cnt_hi;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign cnt_en = en_q;
  assign rdata  = rdata_q;

endmodule

// File: rtl/split_read_counter.sv
module split_read_counter
  import scr_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = DEF_CTRL_ADDR,
  parameter logic [ADDR_W-1:0] LO_ADDR   = DEF_LO_ADDR,
  parameter logic [ADDR_W-1:0] HI_ADDR   = DEF_HI_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              irq_taken,
  output logic [HALF_W-1:0] rdata
);
  logic [HALF_W-1:0] cnt_lo;
  logic [HALF_W-1:0] cnt_hi;
  logic              hi_step;
  logic              cnt_en;
  logic              lo_rd;
  logic              hi_rd;
  logic              pair_ok;
  trk_e              trk_state;

  scr_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (cnt_en),
    .lo      (cnt_lo),
    .hi      (cnt_hi),
    .hi_step (hi_step)
  );

  scr_read_tracker u_trk (
    .clk       (clk),
    .rst       (rst),
    .lo_rd     (lo_rd),
    .hi_rd     (hi_rd),
    .irq_taken (irq_taken),
    .hi_step   (hi_step),
    .state     (trk_state)
  );

  assign pair_ok = (trk_state == TRK_OK);

  scr_regport #(
    .HALF_W    (HALF_W),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .LO_ADDR   (LO_ADDR),
    .HI_ADDR   (HI_ADDR)
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_en   (rd_en),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .pair_ok (pair_ok),
    .cnt_en  (cnt_en),
    .lo_rd   (lo_rd),
    .hi_rd   (hi_rd),
    .rdata   (rdata)
  );

endmodule

// File: rtl/split_read_counter_chk.sv
module split_read_counter_chk
  import scr_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h103
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              wbit0,
  input logic              irq_taken,
  input logic              cnt_en,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              hi_rd,
  input trk_e              trk_state,
  input logic              pair_ok
);

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR) |=> (cnt_en == $past(wbit0))); // R2

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R3

  AST_STEP_ON: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !(&cnt_lo)) |=>
      (cnt_lo == HALF_W'($past(cnt_lo) + 1'b1) && $stable(cnt_hi))); // R3

  AST_CARRY_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && (&cnt_lo)) |=>
      (cnt_lo == '0 && cnt_hi == HALF_W'($past(cnt_hi) + 1'b1))); // R4

  AST_IRQ_SPOILS: assert property (@(posedge clk) disable iff (rst)
    (hi_rd && irq_taken) |=> !pair_ok); // R7

  AST_ORPHAN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (hi_rd && trk_state != TRK_LO) |=> !pair_ok); // R9

endmodule

bind split_read_counter split_read_counter_chk #(
  .HALF_W    (HALF_W),
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr_en     (wr_en),
  .wbit0     (wdata[0]),
  .irq_taken (irq_taken),
  .cnt_en    (cnt_en),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .hi_rd     (hi_rd),
  .trk_state (trk_state),
  .pair_ok   (pair_ok)
);

// File: tb/split_read_counter_bench.sv
`timescale 1ns/1ps
module split_read_counter_bench;
  localparam int unsigned HW = 8;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] A_CTRL = 12'h103;
  localparam logic [AW-1:0] A_LO   = 12'h104;
  localparam logic [AW-1:0] A_HI   = 12'h105;
  localparam logic [HW-1:0] ONES   = '1;

  typedef struct packed {
    logic [1:0] irq;   // 0 none, 1 in gap, 2 at high read, 3 at low read
    logic [1:0] wrap;  // 0 avoid, 1 low wraps at low read, 2 at high read, 3 in between
    logic [3:0] gap;
    logic [7:0] pre;
    logic       ok;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 2'd0, 4'd0, 8'd2, 1'b1},
    '{2'd0, 2'd0, 4'd5, 8'd1, 1'b1},
    '{2'd1, 2'd0, 4'd3, 8'd0, 1'b0},
    '{2'd2, 2'd0, 4'd2, 8'd3, 1'b0},
    '{2'd3, 2'd0, 4'd1, 8'd0, 1'b0},
    '{2'd0, 2'd1, 4'd2, 8'd0, 1'b0},
    '{2'd0, 2'd2, 4'd3, 8'd0, 1'b1},
    '{2'd0, 2'd3, 4'd2, 8'd0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [HW-1:0] wdata = '0;
  logic          rd_en = 1'b0;
  logic          irq_taken = 1'b0;
  logic [HW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2*HW-1:0] m_cnt;
  logic            m_en;

  always #10 clk = ~clk;

  split_read_counter #(.HALF_W(HW), .ADDR_W(AW)) u_split_read_counter (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rd_en     (rd_en),
    .irq_taken (irq_taken),
    .rdata     (rdata)
  );

  // expected count and enable, taken from R1..R3 and R10
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0;
      m_en  <= 1'b0;
    end else begin
      if (m_en) m_cnt <= m_cnt + 1'b1;
      if (wr_en && addr == A_CTRL) m_en <= wdata[0];
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns rdata one rising edge later
  task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [HW-1:0] wd, input logic irq,
                      output logic [HW-1:0] res);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; irq_taken = irq;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; irq_taken = 1'b0;
    res = rdata;
  endtask

  task automatic idle(input int n);
    logic [HW-1:0] dummy;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, 1'b0, dummy);
  endtask

  initial begin
    logic [HW-1:0] r, r2, lo_exp, hi_exp, hi_at_lo, target;
    bit found;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata after reset", rdata, '0);
    step(1'b1, 1'b0, A_CTRL, '0, 1'b0, r);
    chk("R1 control after reset", r, '0);
    idle(3);
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    chk("R1 count zero and held", r, '0);

    // R2: only bit 0 is taken
    step(1'b0, 1'b1, A_CTRL, 8'hFE, 1'b0, r);
    step(1'b1, 1'b0, A_CTRL, '0, 1'b0, r);
    chk("R2 write without bit0", r, 8'h00);
    step(1'b0, 1'b1, A_CTRL, 8'h81, 1'b0, r);
    step(1'b1, 1'b0, A_CTRL, '0, 1'b0, r);
    chk("R2 enable readback", r, 8'h01);

    // R3: steady count
    lo_exp = m_cnt[HW-1:0];
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    chk("R3 low read", r, lo_exp);
    idle(3);
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r2);
    chk("R3 one per cycle", r2 - r, 8'd4);

    // R10: writes to count addresses ignored
    step(1'b0, 1'b1, A_LO, 8'h55, 1'b0, r);
    step(1'b0, 1'b1, A_HI, 8'hAA, 1'b0, r);
    lo_exp = m_cnt[HW-1:0];
    hi_exp = m_cnt[2*HW-1:HW];
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    chk("R10 low unaffected", r, lo_exp);
    step(1'b1, 1'b0, A_HI, '0, 1'b0, r);
    chk("R10 high unaffected", r, hi_exp);

    // R5: unmapped address
    step(1'b1, 1'b0, 12'h106, '0, 1'b0, r);
    chk("R5 unmapped reads zero", r, '0);

    // table of read pairs: R6, R7, R8
    for (int k = 0; k < NROWS; k++) begin
      idle(int'(ROWS[k].pre));
      found = 1'b0;
      for (int w = 0; w < 600 && !found; w++) begin
        case (ROWS[k].wrap)
          2'd1: target = ONES;
          2'd2: target = ONES - HW'(ROWS[k].gap) - 1'b1;
          2'd3: target = ONES - 1'b1;
          default: target = '0;
        endcase
        if (ROWS[k].wrap == 2'd0)
          found = (m_cnt[HW-1:0] <= ONES - HW'(ROWS[k].gap) - 8'd2);
        else
          found = (m_cnt[HW-1:0] == target);
        if (!found) idle(1);
      end
      lo_exp   = m_cnt[HW-1:0];
      hi_at_lo = m_cnt[2*HW-1:HW];
      step(1'b1, 1'b0, A_LO, '0, ROWS[k].irq == 2'd3, r);
      chk($sformatf("R6 row %0d low value", k), r, lo_exp);
      for (int g = 0; g < int'(ROWS[k].gap); g++) begin
        step(1'b0, 1'b0, '0, '0, (ROWS[k].irq == 2'd1) && g == 0, r2);
      end
      hi_exp = m_cnt[2*HW-1:HW];
      step(1'b1, 1'b0, A_HI, '0, ROWS[k].irq == 2'd2, r2);
      chk($sformatf("R6 row %0d high value", k), r2, hi_exp);
      step(1'b1, 1'b0, A_CTRL, '0, 1'b0, r);
      chk($sformatf("R7 R8 row %0d status", k), r, {ROWS[k].ok, 6'd0, 1'b1});
      if (ROWS[k].ok) chk($sformatf("R6 row %0d high stable", k), r2, hi_at_lo);
    end

    // R4: carry on the wrap edge
    found = 1'b0;
    for (int w = 0; w < 600 && !found; w++) begin
      found = (m_cnt[HW-1:0] == ONES);
      if (!found) idle(1);
    end
    hi_at_lo = m_cnt[2*HW-1:HW];
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    chk("R4 low at all-ones", r, ONES);
    step(1'b1, 1'b0, A_HI, '0, 1'b0, r);
    chk("R4 high stepped with wrap", r, hi_at_lo + 1'b1);

    // R9: orphan high read, then restart by a second low read
    idle(2);
    step(1'b1, 1'b0, A_HI, '0, 1'b0, r);
    step(1'b1, 1'b0, A_CTRL, '0, 1'b0, r);
    chk("R9 high without low", r, 8'h01);
    found = 1'b0;
    for (int w = 0; w < 600 && !found; w++) begin
      found = (m_cnt[HW-1:0] < 8'd200);
      if (!found) idle(1);
    end
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    step(1'b0, 1'b0, '0, '0, 1'b1, r);
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    step(1'b1, 1'b0, A_HI, '0, 1'b0, r);
    step(1'b1, 1'b0, A_CTRL, '0, 1'b0, r);
    chk("R9 low read restarts", r, 8'h81);

    // R3: hold when disabled
    step(1'b0, 1'b1, A_CTRL, 8'h00, 1'b0, r);
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r);
    idle(5);
    step(1'b1, 1'b0, A_LO, '0, 1'b0, r2);
    chk("R3 held while disabled", r2, r);
    chk("R5 matches expected count", r2, m_cnt[HW-1:0]);

    finish_run();
  end

endmodule